// File: doc/BRIEF.md
# Dual-Port Bus Lock Register

This block holds a single 16-bit lock register that two bus ports can reach, a local port A and a remote port B. When port A writes 1 to the lock bit, the block asks the arbiter of bus B for ownership. When port B writes 1 to the lock bit, the block asks the arbiter of bus A for ownership. While that ownership is held, the owning side can run indivisible sequences on the other bus. The request stays up, and ownership is kept, until the same port writes 0 to the lock bit or a hard or soft reset occurs.

The register returns different content to each port. A read from port A shows whether bus B is owned. A read from port B shows whether bus A is owned. The lock bit reads as 1 only after the arbiter has granted the bus, so software polls the bit until the lock is really in force. The upper fifteen bits are fixed ones. Both byte lanes can be written independently, so 8-bit and 16-bit accesses both work. Each arbiter connection is a plain request/grant pair. An optional synchronizer on each grant input is chosen by a parameter.

Top module: `dual_port_lock_reg`

## Requirements
- R1: After hard reset both bus requests are low, and a read of the register at offset 0x22 returns 0xFFFE from either port.
- R2: Bits 15 to 1 always read as 1, whatever value was last written to them.
- R3: A write to offset 0x22 with the low byte lane enabled (be[0]) and data bit 0 equal to 1 raises the request one clock after the write strobe. A write from port A raises bus_b_req. A write from port B raises bus_a_req.
- R4: After the grant is taken, the request and the ownership stay set until the lock bit is cleared or a reset occurs. This holds through repeated set writes and through other accesses. The arbiter must keep its grant up for as long as ownership is held.
- R5: Read bit 0 is 0 until the grant has been sampled while the request is high. It becomes 1 one clock after the first edge at which both the request and the grant are high. Bit 0 of a port A read shows bus B ownership. Bit 0 of a port B read shows bus A ownership.
- R6: A write of 0 to bit 0 at offset 0x22 with be[0] set drops the matching request and the ownership at the next clock edge.
- R7: A synchronous soft reset and the asynchronous active-low hard reset each clear both requests and both ownership flags.
- R8: The two locks are tracked independently. Both ports may set their locks in the same cycle. An action on one port never changes the other port's request or readback.
- R9: A write with be[0] low (upper byte only), or a write to any offset other than 0x22, changes no request and no readback.
- R10: Read data is all zeros when the port is not reading offset 0x22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| a_sel | input | 1 | Port A access strobe |
| a_wr | input | 1 | Port A write (1) or read (0) |
| a_addr | input | 8 | Port A register offset |
| a_be | input | 2 | Port A byte lane enables, bit 0 = low byte |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A read data (combinational) |
| b_sel | input | 1 | Port B access strobe |
| b_wr | input | 1 | Port B write (1) or read (0) |
| b_addr | input | 8 | Port B register offset |
| b_be | input | 2 | Port B byte lane enables, bit 0 = low byte |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B read data (combinational) |
| bus_b_req | output | 1 | Ownership request to the bus B arbiter (set by port A) |
| bus_b_gnt | input | 1 | Grant from the bus B arbiter |
| bus_a_req | output | 1 | Ownership request to the bus A arbiter (set by port B) |
| bus_a_gnt | input | 1 | Grant from the bus A arbiter |

## Verification
The request follows the write strobe by one clock edge. The bench therefore checks the request pin on the falling edge right after the edge that captured the write. Ownership, and so read bit 0, follows the first edge at which the request and the grant are both high, which is one edge later when the grant is already up. The read task drives the strobe on a falling edge and samples the combinational read data 1 ns later, before any rising edge. Each read therefore shows the state as of the previous edge, and the grant-to-readback delay is checked exactly, not just eventually. Clears and soft resets take effect at the next edge, and the hard reset takes effect at once; both are checked at the pins before any new stimulus.

// File: rtl/lockreg_pkg.sv
package lockreg_pkg;
   // side index: which port's writes drive which far-bus request
   localparam int unsigned SIDE_A = 0;   // port A -> requests bus B
   localparam int unsigned SIDE_B = 1;   // port B -> requests bus A
   localparam int unsigned NSIDES = 2;

   typedef struct packed {
      logic set;
      logic clr;
      logic rd_hit;
   } lock_cmd_t;
endpackage

// File: rtl/lockreg_decode.sv
module lockreg_decode #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned OFFSET   = 'h22,
   parameter int unsigned LOCK_BIT = 0,
   localparam int unsigned BE_W      = DATA_W / 8,
   localparam int unsigned LOCK_LANE = LOCK_BIT / 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sel,
   input  logic                wr,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [BE_W-1:0]     be,
   input  logic [DATA_W-1:0]   wdata,
   output lockreg_pkg::lock_cmd_t cmd
);
   logic hit;
   logic lane_wr;
   logic unused_wdata;

   assign hit          = sel && (addr == ADDR_W'(OFFSET));
   assign lane_wr      = hit && wr && be[LOCK_LANE];
   assign cmd.set      = lane_wr &&  wdata[LOCK_BIT];
   assign cmd.clr      = lane_wr && !wdata[LOCK_BIT];
   assign cmd.rd_hit   = hit && !wr;
   assign unused_wdata = ^wdata;

   // a write that leaves the lock lane disabled issues no command
   p_lane_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr && !be[LOCK_LANE]) |-> (!cmd.set && !cmd.clr));
   // other offsets issue nothing at all
   p_offset_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && addr != ADDR_W'(OFFSET)) |-> (!cmd.set && !cmd.clr && !cmd.rd_hit));
endmodule

// File: rtl/lockreg_side.sv
module lockreg_side #(
   parameter int unsigned GNT_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic set_i,
   input  logic clr_i,
   input  logic gnt_i,
   output logic req_o,
   output logic owned_o
);
   logic gnt_s;
   logic req_q;
   logic owned_q;

   generate
      if (GNT_STAGES == 0) begin : g_gnt_direct
         assign gnt_s = gnt_i;
      end else begin : g_gnt_sync
         logic [GNT_STAGES-1:0] gnt_pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) gnt_pipe <= '0;
            else if (GNT_STAGES == 1) gnt_pipe <= gnt_i;
            else gnt_pipe <= {gnt_pipe[GNT_STAGES-2:0], gnt_i};
         end
         assign gnt_s = gnt_pipe[GNT_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= 1'b0;
         owned_q <= 1'b0;
      end else if (soft_rst || clr_i) begin
         req_q   <= 1'b0;
         owned_q <= 1'b0;
      end else begin
         if (set_i) req_q <= 1'b1;
         if (req_q && gnt_s) owned_q <= 1'b1;
      end
   end

   assign req_o   = req_q;
   assign owned_o = owned_q;

   p_set_raises_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !soft_rst) |=> req_o);
   p_owned_implies_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      owned_o |-> req_o);
   p_owned_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (owned_o && !clr_i && !soft_rst) |=> owned_o);
   p_grant_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      owned_o |-> gnt_s);
   p_no_own_without_gnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!owned_o && !(req_o && gnt_s)) |=> !owned_o);
   p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (!req_o && !owned_o));
   p_soft_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!req_o && !owned_o));
endmodule

// File: rtl/dual_port_lock_reg.sv
module dual_port_lock_reg #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned OFFSET     = 'h22,
   parameter int unsigned LOCK_BIT   = 0,
   parameter int unsigned GNT_STAGES = 0,
   localparam int unsigned BE_W      = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              a_sel,
   input  logic              a_wr,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [BE_W-1:0]   a_be,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              b_sel,
   input  logic              b_wr,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [BE_W-1:0]   b_be,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata,
   output logic              bus_b_req,
   input  logic              bus_b_gnt,
   output logic              bus_a_req,
   input  logic              bus_a_gnt
);
   import lockreg_pkg::*;

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
         $error("DATA_W must be a non-zero multiple of 8");
      end
      if (LOCK_BIT >= DATA_W) begin : g_bad_bit
         $error("LOCK_BIT must lie inside the register");
      end
      if (GNT_STAGES > 3) begin : g_bad_sync
         $error("GNT_STAGES must be 0 to 3");
      end
      if (OFFSET >= (1 << ADDR_W)) begin : g_bad_offset
         $error("OFFSET does not fit in ADDR_W");
      end
   endgenerate

   logic              sel_v   [NSIDES];
   logic              wr_v    [NSIDES];
   logic [ADDR_W-1:0] addr_v  [NSIDES];
   logic [BE_W-1:0]   be_v    [NSIDES];
   logic [DATA_W-1:0] wdata_v [NSIDES];
   logic [DATA_W-1:0] rdata_v [NSIDES];
   logic              gnt_v   [NSIDES];
   logic              req_v   [NSIDES];
   logic              owned_v [NSIDES];
   lock_cmd_t         cmd_v   [NSIDES];

   assign sel_v[SIDE_A]   = a_sel;
   assign wr_v[SIDE_A]    = a_wr;
   assign addr_v[SIDE_A]  = a_addr;
   assign be_v[SIDE_A]    = a_be;
   assign wdata_v[SIDE_A] = a_wdata;
   assign gnt_v[SIDE_A]   = bus_b_gnt;
   assign sel_v[SIDE_B]   = b_sel;
   assign wr_v[SIDE_B]    = b_wr;
   assign addr_v[SIDE_B]  = b_addr;
   assign be_v[SIDE_B]    = b_be;
   assign wdata_v[SIDE_B] = b_wdata;
   assign gnt_v[SIDE_B]   = bus_a_gnt;

   generate
      for (genvar s = 0; s < NSIDES; s++) begin : g_side
         logic [DATA_W-1:0] word;

         lockreg_decode #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W),
            .OFFSET(OFFSET), .LOCK_BIT(LOCK_BIT)
         ) u_dec (
            .clk(clk), .rst_n(rst_n),
            .sel(sel_v[s]), .wr(wr_v[s]), .addr(addr_v[s]),
            .be(be_v[s]), .wdata(wdata_v[s]), .cmd(cmd_v[s])
         );

         lockreg_side #(.GNT_STAGES(GNT_STAGES)) u_side (
            .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
            .set_i(cmd_v[s].set), .clr_i(cmd_v[s].clr),
            .gnt_i(gnt_v[s]), .req_o(req_v[s]), .owned_o(owned_v[s])
         );

         for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            if (b == LOCK_BIT) begin : g_lock
               assign word[b] = owned_v[s];
            end else begin : g_fixed
               assign word[b] = 1'b1;
            end
         end

         assign rdata_v[s] = cmd_v[s].rd_hit ? word : '0;
      end
   endgenerate

   assign a_rdata   = rdata_v[SIDE_A];
   assign b_rdata   = rdata_v[SIDE_B];
   assign bus_b_req = req_v[SIDE_A];
   assign bus_a_req = req_v[SIDE_B];

   p_idle_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_sel || a_wr) |-> (a_rdata == '0));
   p_reserved_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
      b_sel && !b_wr && b_addr == ADDR_W'(OFFSET) |->
         ((b_rdata | DATA_W'(1 << LOCK_BIT)) == '1));
   p_b_quiet_keeps_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!b_sel && !soft_rst && !bus_a_req) |=> !bus_a_req);
endmodule

// File: tb/dual_port_lock_reg_bench.sv
module dual_port_lock_reg_bench;
   localparam logic [7:0] OFS = 8'h22;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic        a_sel = 0, a_wr = 0, b_sel = 0, b_wr = 0;
   logic [7:0]  a_addr = 0, b_addr = 0;
   logic [1:0]  a_be = 0, b_be = 0;
   logic [15:0] a_wdata = 0, b_wdata = 0;
   logic [15:0] a_rdata, b_rdata;
   logic        bus_b_req, bus_a_req;
   logic        bus_b_gnt = 0, bus_a_gnt = 0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   dual_port_lock_reg u_dual_port_lock_reg (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_be(a_be),
      .a_wdata(a_wdata), .a_rdata(a_rdata),
      .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_be(b_be),
      .b_wdata(b_wdata), .b_rdata(b_rdata),
      .bus_b_req(bus_b_req), .bus_b_gnt(bus_b_gnt),
      .bus_a_req(bus_a_req), .bus_a_gnt(bus_a_gnt)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end on a falling edge
   task automatic wr_a(input logic [7:0] ad, input logic [1:0] be, input logic [15:0] d);
      a_sel = 1; a_wr = 1; a_addr = ad; a_be = be; a_wdata = d;
      @(negedge clk);
      a_sel = 0; a_wr = 0;
   endtask

   task automatic wr_b(input logic [7:0] ad, input logic [1:0] be, input logic [15:0] d);
      b_sel = 1; b_wr = 1; b_addr = ad; b_be = be; b_wdata = d;
      @(negedge clk);
      b_sel = 0; b_wr = 0;
   endtask

   task automatic rd_a(input logic [7:0] ad, output logic [15:0] d);
      a_sel = 1; a_wr = 0; a_addr = ad;
      #1 d = a_rdata;
      @(negedge clk);
      a_sel = 0;
   endtask

   task automatic rd_b(input logic [7:0] ad, output logic [15:0] d);
      b_sel = 1; b_wr = 0; b_addr = ad;
      #1 d = b_rdata;
      @(negedge clk);
      b_sel = 0;
   endtask

   task automatic t_reset;
      logic [15:0] d;
      chk("R1 bus_b_req", {15'b0, bus_b_req}, 16'h0);
      chk("R1 bus_a_req", {15'b0, bus_a_req}, 16'h0);
      rd_a(OFS, d); chk("R1 read A", d, 16'hFFFE);
      rd_b(OFS, d); chk("R1 read B", d, 16'hFFFE);
   endtask

   task automatic t_lock_a;
      logic [15:0] d;
      bus_b_gnt = 1;
      wr_a(OFS, 2'b01, 16'h0001);
      chk("R3 bus_b_req after A set", {15'b0, bus_b_req}, 16'h1);
      chk("R8 bus_a_req untouched", {15'b0, bus_a_req}, 16'h0);
      rd_a(OFS, d); chk("R5 not yet owned", d, 16'hFFFE);
      rd_a(OFS, d); chk("R5 owned one edge after grant", d, 16'hFFFF);
      rd_b(OFS, d); chk("R8 B view unaffected", d, 16'hFFFE);
      wr_a(OFS, 2'b11, 16'h0001);
      rd_a(OFS, d); chk("R4 held across re-set", d, 16'hFFFF);
      wr_a(OFS, 2'b10, 16'h0000);
      rd_a(OFS, d); chk("R9 upper byte write ignored", d, 16'hFFFF);
      chk("R9 req kept", {15'b0, bus_b_req}, 16'h1);
      wr_a(8'h20, 2'b11, 16'h0000);
      rd_a(OFS, d); chk("R9 other offset ignored", d, 16'hFFFF);
      wr_a(OFS, 2'b01, 16'h0000);
      chk("R6 req dropped", {15'b0, bus_b_req}, 16'h0);
      rd_a(OFS, d); chk("R6 readback cleared", d, 16'hFFFE);
      bus_b_gnt = 0;
   endtask

   task automatic t_lock_b_slow_grant;
      logic [15:0] d;
      wr_b(OFS, 2'b11, 16'h0001);
      chk("R3 bus_a_req after B set", {15'b0, bus_a_req}, 16'h1);
      rd_b(OFS, d); chk("R5 no grant yet 1", d, 16'hFFFE);
      rd_b(OFS, d); chk("R5 no grant yet 2", d, 16'hFFFE);
      bus_a_gnt = 1;
      rd_b(OFS, d); chk("R5 grant not yet sampled", d, 16'hFFFE);
      rd_b(OFS, d); chk("R5 owned after grant", d, 16'hFFFF);
      rd_a(OFS, d); chk("R8 A view unaffected", d, 16'hFFFE);
      wr_b(OFS, 2'b11, 16'hFFFE);
      chk("R6 bus_a_req dropped", {15'b0, bus_a_req}, 16'h0);
      rd_b(OFS, d); chk("R2 reserved ones after zero-bit write", d, 16'hFFFE);
      bus_a_gnt = 0;
   endtask

   task automatic t_both_then_soft;
      logic [15:0] d;
      bus_a_gnt = 1; bus_b_gnt = 1;
      a_sel = 1; a_wr = 1; a_addr = OFS; a_be = 2'b11; a_wdata = 16'hFFFF;
      b_sel = 1; b_wr = 1; b_addr = OFS; b_be = 2'b01; b_wdata = 16'h0001;
      @(negedge clk);
      a_sel = 0; a_wr = 0; b_sel = 0; b_wr = 0;
      chk("R8 both reqs", {14'b0, bus_a_req, bus_b_req}, 16'h3);
      @(negedge clk);
      rd_a(OFS, d); chk("R8 A owns bus B", d, 16'hFFFF);
      rd_b(OFS, d); chk("R8 B owns bus A", d, 16'hFFFF);
      soft_rst = 1;
      @(negedge clk);
      soft_rst = 0;
      chk("R7 soft reset reqs", {14'b0, bus_a_req, bus_b_req}, 16'h0);
      rd_a(OFS, d); chk("R7 soft reset A read", d, 16'hFFFE);
      bus_a_gnt = 0; bus_b_gnt = 0;
   endtask

   task automatic t_hard_reset;
      logic [15:0] d;
      bus_b_gnt = 1;
      wr_a(OFS, 2'b01, 16'h0001);
      @(negedge clk);
      rd_a(OFS, d); chk("R4 owned before hard reset", d, 16'hFFFF);
      #1 rst_n = 0;
      #1 chk("R7 hard reset req", {15'b0, bus_b_req}, 16'h0);
      bus_b_gnt = 0;
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      rd_a(OFS, d); chk("R7 hard reset read", d, 16'hFFFE);
   endtask

   task automatic t_idle_read;
      logic [15:0] d;
      #1 chk("R10 idle A rdata", a_rdata, 16'h0);
      chk("R10 idle B rdata", b_rdata, 16'h0);
      rd_b(8'h24, d); chk("R10 other offset read", d, 16'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_lock_a();
      t_lock_b_slow_grant();
      t_both_then_soft();
      t_hard_reset();
      t_idle_read();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule